// File: doc/BRIEF.md
# Non-volatile Macro Power and Idle Sequencer

This block drives the reset and idle pins of an embedded multi-time-programmable memory macro. It works from a system power-good input, a sleep request, a wake request and a reset request. While the supply is not valid, both macro pins are held low, so noise on the write strobes cannot disturb stored bits. Once the supply is valid, the block counts out the settling time the macro needs before it reports ready. It counts separate delays after power-up, after a requested reset and after a wake from idle.

The block also sits in the path of the access controller's chip-enable, write-enable, program-enable and erase-enable strobes. It forces all four to their inactive (high) level whenever the macro is not ready. A sleep request is only accepted while the access controller reports no operation in progress. All delays are given as clock-cycle counts, set through parameters.

Top module: `mtp_pwr_seq`

## Requirements
- R1: While the system reset is active, `mac_rst_n`, `mac_idle_n` and `ready` are 0, and all four gated strobes are 1.
- R2: After `pwr_good` is first seen high, `mac_rst_n` stays low for RST_LOW_CYC cycles and rises at the (RST_LOW_CYC+1)-th clock edge, with `mac_idle_n` high. `ready` rises PWRUP_CYC edges after that.
- R3: When `pwr_good` is low, `mac_rst_n`, `mac_idle_n` and `ready` are 0 in the same cycle with no clock edge in between. When power returns, the full power-up sequence of R2 restarts.
- R4: A `rst_req` sampled while ready pulls `mac_rst_n` low for RST_LOW_CYC cycles; it rises at edge RST_LOW_CYC+1 counted from the request edge. `ready` follows RST_EXIT_CYC edges after that.
- R5: A `sleep_req` sampled while ready with `busy` low drives `mac_idle_n` and `ready` low from the next edge.
- R6: A `sleep_req` sampled while `busy` is high is ignored: `mac_idle_n` and `ready` stay high.
- R7: Idle lasts at least IDLE_MIN_CYC cycles whatever `wake_req` does. `wake_req` is a level: a pulse that has ended before the minimum time has passed does not wake the macro.
- R8: With `wake_req` high and the minimum idle time elapsed, `mac_idle_n` rises at the next edge. `ready` follows WAKE_CYC edges after that.
- R9: When `ready` is 0, `mac_ce_n`, `mac_we_n`, `mac_pgm_n` and `mac_ers_n` are 1. When `ready` is 1, each equals its `ctl_*` input.
- R10: `rst_req` takes priority over `sleep_req` in the same cycle. `rst_req` is ignored outside the ready state; in particular it has no effect while the macro is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| pwr_good | input | 1 | Supply valid indication |
| sleep_req | input | 1 | Request to enter idle |
| wake_req | input | 1 | Level request to leave idle |
| rst_req | input | 1 | Request to reset the macro |
| busy | input | 1 | Access controller has an operation in progress |
| ctl_ce_n | input | 1 | Chip enable from access controller |
| ctl_we_n | input | 1 | Write enable from access controller |
| ctl_pgm_n | input | 1 | Program enable from access controller |
| ctl_ers_n | input | 1 | Erase enable from access controller |
| mac_rst_n | output | 1 | Macro reset pin |
| mac_idle_n | output | 1 | Macro idle pin (low = idle) |
| mac_ce_n | output | 1 | Gated chip enable |
| mac_we_n | output | 1 | Gated write enable |
| mac_pgm_n | output | 1 | Gated program enable |
| mac_ers_n | output | 1 | Gated erase enable |
| ready | output | 1 | Macro may be accessed |

## Verification
Two functions can meet in one cycle. One case is a reset request and a sleep request raised together while ready. The bench drives both at the same negative edge. It then checks that the idle pin never falls while the reset pin drops and the reset-exit latency runs out in full. The other case is a power-good drop that arrives while a timed phase is running. The bench removes power between edges and samples the pins before the next edge, then confirms the power-up count restarts from zero.

// File: rtl/mtp_seq_pkg.sv
package mtp_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_PU_RST,
        S_PU_WAIT,
        S_READY,
        S_RR_LOW,
        S_RR_WAIT,
        S_IDLE,
        S_WAKE
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       pin_rst_n;
        logic       pin_idle_n;
        logic       rdy;
    } seq_regs_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mtp_seq_timer.sv
module mtp_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/mtp_seq_fsm.sv
module mtp_seq_fsm
    import mtp_seq_pkg::*;
#(
    parameter int RST_LOW_CYC  = 2,
    parameter int PWRUP_CYC    = 10000,
    parameter int RST_EXIT_CYC = 1000,
    parameter int IDLE_MIN_CYC = 500,
    parameter int WAKE_CYC     = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic rst_req,
    input  logic busy,
    output logic pin_rst_n,
    output logic pin_idle_n,
    output logic rdy
);
    localparam int MAX_CYC = max2(max2(max2(RST_LOW_CYC, PWRUP_CYC),
                                       max2(RST_EXIT_CYC, IDLE_MIN_CYC)), WAKE_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_RST_LOW  = CNT_W'(RST_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PWRUP    = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RST_EXIT = CNT_W'(RST_EXIT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_IDLE_MIN = CNT_W'(IDLE_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WAKE     = CNT_W'(WAKE_CYC - 1);

    seq_regs_t        q, d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    mtp_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!pwr_good) begin
            d.state = S_OFF;
        end else begin
            unique case (q.state)
                S_OFF: begin
                    d.state  = S_PU_RST;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST_LOW;
                end
                S_PU_RST: if (tmr_zero) begin
                    d.state  = S_PU_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PWRUP;
                end
                S_PU_WAIT: if (tmr_zero) d.state = S_READY;
                S_READY: begin
                    if (rst_req) begin
                        d.state  = S_RR_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RST_LOW;
                    end else if (sleep_req && !busy) begin
                        d.state  = S_IDLE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_IDLE_MIN;
                    end
                end
                S_RR_LOW: if (tmr_zero) begin
                    d.state  = S_RR_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST_EXIT;
                end
                S_RR_WAIT: if (tmr_zero) d.state = S_READY;
                S_IDLE: if (tmr_zero && wake_req) begin
                    d.state  = S_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WAKE;
                end
                S_WAKE: if (tmr_zero) d.state = S_READY;
                default: d.state = S_OFF;
            endcase
        end
        d.pin_rst_n  = !(d.state inside {S_OFF, S_PU_RST, S_RR_LOW});
        d.pin_idle_n = !(d.state inside {S_OFF, S_IDLE});
        d.rdy        = (d.state == S_READY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_OFF, pin_rst_n: 1'b0, pin_idle_n: 1'b0, rdy: 1'b0};
        else        q <= d;
    end

    assign pin_rst_n  = q.pin_rst_n;
    assign pin_idle_n = q.pin_idle_n;
    assign rdy        = q.rdy;

    AST_RDY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(q.state) inside {S_PU_WAIT, S_RR_WAIT, S_WAKE})); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && !tmr_zero && pwr_good) |=> (q.state == S_IDLE)); // R7

    AST_NO_SLEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_READY && busy) |=> (q.state != S_IDLE)); // R6

    AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_READY && rst_req && pwr_good) |=> (q.state == S_RR_LOW)); // R10

endmodule

// File: rtl/mtp_seq_gate.sv
module mtp_seq_gate #(
    parameter int NUM_EN = 4
) (
    input  logic              ready_i,
    input  logic [NUM_EN-1:0] en_n_i,
    output logic [NUM_EN-1:0] en_n_o
);
    for (genvar i = 0; i < NUM_EN; i++) begin : g_en
        assign en_n_o[i] = ready_i ? en_n_i[i] : 1'b1;
    end
endmodule

// File: rtl/mtp_pwr_seq.sv
module mtp_pwr_seq #(
    parameter int RST_LOW_CYC  = 2,
    parameter int PWRUP_CYC    = 10000,
    parameter int RST_EXIT_CYC = 1000,
    parameter int IDLE_MIN_CYC = 500,
    parameter int WAKE_CYC     = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic rst_req,
    input  logic busy,
    input  logic ctl_ce_n,
    input  logic ctl_we_n,
    input  logic ctl_pgm_n,
    input  logic ctl_ers_n,
    output logic mac_rst_n,
    output logic mac_idle_n,
    output logic mac_ce_n,
    output logic mac_we_n,
    output logic mac_pgm_n,
    output logic mac_ers_n,
    output logic ready
);
    localparam int NUM_EN = 4;

    logic              pin_rst_n, pin_idle_n, rdy;
    logic [NUM_EN-1:0] en_in, en_out;

    mtp_seq_fsm #(
        .RST_LOW_CYC  (RST_LOW_CYC),
        .PWRUP_CYC    (PWRUP_CYC),
        .RST_EXIT_CYC (RST_EXIT_CYC),
        .IDLE_MIN_CYC (IDLE_MIN_CYC),
        .WAKE_CYC     (WAKE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .rst_req    (rst_req),
        .busy       (busy),
        .pin_rst_n  (pin_rst_n),
        .pin_idle_n (pin_idle_n),
        .rdy        (rdy)
    );

    assign mac_rst_n  = pin_rst_n  & pwr_good;
    assign mac_idle_n = pin_idle_n & pwr_good;
    assign ready      = rdy        & pwr_good;

    assign en_in = {ctl_ce_n, ctl_we_n, ctl_pgm_n, ctl_ers_n};

    mtp_seq_gate #(.NUM_EN(NUM_EN)) u_gate (
        .ready_i (ready),
        .en_n_i  (en_in),
        .en_n_o  (en_out)
    );

    assign {mac_ce_n, mac_we_n, mac_pgm_n, mac_ers_n} = en_out;

    AST_PG_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> (!mac_rst_n && !mac_idle_n && !ready)); // R3

    AST_STROBES_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (mac_ce_n && mac_we_n && mac_pgm_n && mac_ers_n)); // R9

endmodule

// File: tb/sim_mtp_pwr_seq.sv
module sim_mtp_pwr_seq;
    localparam int RL = 3, PU = 40, RX = 12, IM = 10, WK = 25;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwr_good = 0, sleep_req = 0, wake_req = 0, rst_req = 0, busy = 0;
    logic ctl_ce_n = 0, ctl_we_n = 0, ctl_pgm_n = 0, ctl_ers_n = 0;
    logic mac_rst_n, mac_idle_n, mac_ce_n, mac_we_n, mac_pgm_n, mac_ers_n, ready;

    int checks = 0, failures = 0, gate_viol = 0, idle_fell = 0;
    bit done = 0;
    int expq[$];

    always #5 clk = ~clk;

    mtp_pwr_seq #(.RST_LOW_CYC(RL), .PWRUP_CYC(PU), .RST_EXIT_CYC(RX),
                  .IDLE_MIN_CYC(IM), .WAKE_CYC(WK)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
        .wake_req(wake_req), .rst_req(rst_req), .busy(busy),
        .ctl_ce_n(ctl_ce_n), .ctl_we_n(ctl_we_n), .ctl_pgm_n(ctl_pgm_n),
        .ctl_ers_n(ctl_ers_n), .mac_rst_n(mac_rst_n), .mac_idle_n(mac_idle_n),
        .mac_ce_n(mac_ce_n), .mac_we_n(mac_we_n), .mac_pgm_n(mac_pgm_n),
        .mac_ers_n(mac_ers_n), .ready(ready));

    // gate monitor, sampled at the falling edge (R9)
    always @(negedge clk) if (rst_n) begin
        if (!ready && {mac_ce_n, mac_we_n, mac_pgm_n, mac_ers_n} != 4'hF) gate_viol++;
        if (ready && {mac_ce_n, mac_we_n, mac_pgm_n, mac_ers_n} !=
                     {ctl_ce_n, ctl_we_n, ctl_pgm_n, ctl_ers_n}) gate_viol++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver side: record expected latency
    function automatic void push_exp(input int v);
        expq.push_back(v);
    endfunction

    // monitor side: count edges until the selected output reaches a level, compare with queue head
    task automatic observe(input string req, input int sel, input logic lvl);
        int n = 0;
        int exp;
        logic v;
        do begin
            @(posedge clk); #2; n++;
            v = (sel == 0) ? mac_rst_n : (sel == 1) ? mac_idle_n : ready;
            if (!mac_idle_n && sel == 0) idle_fell++;
        end while (v !== lvl && n < 500);
        exp = expq.pop_front();
        check(req, n, exp);
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk); cyc++;
            if (cyc > 20000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 rst", mac_rst_n, 0);
        check("R1 idle", mac_idle_n, 0);
        check("R1 ready", ready, 0);
        check("R1 strobes", {mac_ce_n, mac_we_n, mac_pgm_n, mac_ers_n}, 4'hF);
        @(negedge clk); rst_n = 1;

        // R2 power-up
        @(negedge clk); pwr_good = 1;
        push_exp(RL + 1); observe("R2 rst rise", 0, 1'b1);
        check("R2 idle high", mac_idle_n, 1);
        push_exp(PU); observe("R2 ready", 2, 1'b1);

        // R9 pass-through while ready
        @(negedge clk); {ctl_ce_n, ctl_we_n, ctl_pgm_n, ctl_ers_n} = 4'b0101; #1;
        check("R9 pass", {mac_ce_n, mac_we_n, mac_pgm_n, mac_ers_n}, 4'b0101);

        // R6 sleep while busy
        @(negedge clk); busy = 1; sleep_req = 1;
        step();
        check("R6 idle", mac_idle_n, 1);
        check("R6 ready", ready, 1);
        @(negedge clk); busy = 0; sleep_req = 0;

        // R10 reset and sleep together
        @(negedge clk); rst_req = 1; sleep_req = 1; idle_fell = 0;
        @(negedge clk); rst_req = 0; sleep_req = 0;
        push_exp(RL); observe("R10 rst rise", 0, 1'b1);
        check("R10 no idle", idle_fell, 0);
        push_exp(RX); observe("R10 ready", 2, 1'b1);

        // R4 plain reset request
        @(negedge clk); rst_req = 1;
        push_exp(RL + 1); observe("R4 rst rise", 0, 1'b1);
        rst_req = 0;
        push_exp(RX); observe("R4 ready", 2, 1'b1);

        // R5 / R7 / R8 sleep with wake already held
        @(negedge clk); sleep_req = 1; wake_req = 1;
        push_exp(1); observe("R5 idle low", 1, 1'b0);
        check("R5 ready", ready, 0);
        sleep_req = 0;
        push_exp(IM); observe("R7 R8 idle min", 1, 1'b1);
        push_exp(WK); observe("R8 ready", 2, 1'b1);

        // R7 short wake pulse, R10 reset ignored in idle
        @(negedge clk); wake_req = 0; sleep_req = 1;
        @(negedge clk); sleep_req = 0; wake_req = 1;
        @(negedge clk); wake_req = 0;
        repeat (IM + 5) step();
        check("R7 still idle", mac_idle_n, 0);
        @(negedge clk); rst_req = 1;
        step();
        check("R10 rst ignored", mac_rst_n, 1);
        @(negedge clk); rst_req = 0; wake_req = 1;
        push_exp(1); observe("R8 idle rise", 1, 1'b1);
        push_exp(WK); observe("R8 ready2", 2, 1'b1);
        wake_req = 0;

        // R3 power loss, then restart
        @(negedge clk); pwr_good = 0; #1;
        check("R3 rst", mac_rst_n, 0);
        check("R3 idle", mac_idle_n, 0);
        check("R3 ready", ready, 0);
        step(); step();
        @(negedge clk); pwr_good = 1;
        push_exp(RL + 1); observe("R3 restart", 0, 1'b1);
        // R3 drop mid power-up wait
        repeat (5) step();
        @(negedge clk); pwr_good = 0; #1;
        check("R3 mid drop", mac_rst_n, 0);
        step();
        @(negedge clk); pwr_good = 1;
        push_exp(RL + 1); observe("R3 restart2", 0, 1'b1);
        push_exp(PU); observe("R3 ready", 2, 1'b1);

        check("R9 gate monitor", gate_viol, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule